// File: doc/BRIEF.md
# Register Rename Map with FIFO Free List

This block renames the registers of one decoded instruction per cycle. It keeps two structures. The first is a table that gives the physical register currently bound to each logical register. The second is a first-in first-out list of physical registers that hold no live value. The physical register file is larger than the logical one, so the free list starts non-empty. Renaming gives every write a fresh physical home, which removes write-after-read and write-after-write hazards between instructions.

In the decode cycle, the block looks up the two logical sources in the table and returns their physical tags combinationally. It also returns the old binding of the logical destination, so later logic can free that register when the instruction commits. For a non-zero destination, the block takes the tag at the head of the free list. At the clock edge it pops that tag and writes it into the table. Logical register zero is hard-wired to physical register zero. If the free list is empty, the block raises a stall and changes nothing. A separate release port puts freed tags back at the tail of the list.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i for every i. The free list holds physical registers NUM_LOG up to NUM_PHYS-1, with the lowest value at the head.
- R2: `physSrcA` and `physSrcB` show the current table entries for `srcA` and `srcB` in the same cycle. An instruction whose source equals its own destination reads the binding from before its own rename.
- R3: A granted rename (`decValid` high, `dst` non-zero, no stall) sets `physDst` to the head of the free list. At the next clock edge the block pops that tag and binds `dst` to it. Successive renames receive tags in free-list order.
- R4: `prevDst` shows the binding of `dst` before the current instruction's rename.
- R5: Logical register 0 always reads as physical 0. With `dst` equal to 0, `physDst` and `prevDst` are 0, no stall is raised and no free entry is used.
- R6: When `decValid` is high, `dst` is non-zero and the free list is empty, `stall` is 1 and `physDst` is 0. Neither the table nor the list changes. A release in that same cycle does not clear the stall.
- R7: A release (`relValid` high) appends `relTag` at the tail of the free list. A release and a granted rename in the same cycle both take effect.
- R8: `stall` is 0 whenever `decValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | A decoded instruction is presented |
| srcA | input | LOG_W | First logical source |
| srcB | input | LOG_W | Second logical source |
| dst | input | LOG_W | Logical destination (0 means no write) |
| relValid | input | 1 | Release a physical tag this cycle |
| relTag | input | PHYS_W | Tag returned to the free list |
| physSrcA | output | PHYS_W | Physical tag of srcA |
| physSrcB | output | PHYS_W | Physical tag of srcB |
| physDst | output | PHYS_W | Newly allocated tag (0 if none) |
| prevDst | output | PHYS_W | Previous binding of dst |
| stall | output | 1 | Rename cannot proceed: no free register |

## Verification
Some properties are checked by assertions on every cycle:
- register zero always reads as physical zero;
- no stall is raised without a pending non-zero write;
- a granted rename never returns tag zero;
- the free-entry count falls by one on a plain allocation, holds on a stall without release, and holds when a release and an allocation coincide.

Other properties can only be shown by the bench's scenarios, because they depend on the whole history of the table and list:
- the exact tags handed out in FIFO order;
- a released tag coming back only after the older free entries;
- the table keeping its old binding across a stall;
- the reset bindings.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef struct packed {
    logic alloc;
    logic release_;
  } rrStrobes_t;
endpackage

// File: rtl/rr_ctrl.sv
module rr_ctrl #(
  parameter int LOG_W = 3
) (
  input  logic             decValid,
  input  logic [LOG_W-1:0] dst,
  input  logic             freeEmpty,
  input  logic             relValid,
  output rr_pkg::rrStrobes_t strobes,
  output logic             stall
);
  logic wantsTag;

  always_comb begin
    wantsTag         = decValid && (dst != '0);
    stall            = wantsTag && freeEmpty;
    strobes.alloc    = wantsTag && !freeEmpty;
    strobes.release_ = relValid;
  end
endmodule

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int NUM_LOG = 8,
  parameter int LOG_W   = 3,
  parameter int PHYS_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [LOG_W-1:0]  wrIdx,
  input  logic [PHYS_W-1:0] wrTag,
  input  logic [LOG_W-1:0]  rdIdxA,
  input  logic [LOG_W-1:0]  rdIdxB,
  input  logic [LOG_W-1:0]  rdIdxC,
  output logic [PHYS_W-1:0] rdTagA,
  output logic [PHYS_W-1:0] rdTagB,
  output logic [PHYS_W-1:0] rdTagC
);
  logic [PHYS_W-1:0] entry [NUM_LOG];

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign entry[i] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN)
          entry[i] <= PHYS_W'(i);
        else if (wrEn && (wrIdx == LOG_W'(i)))
          entry[i] <= wrTag;
      end
    end
  end

  always_comb begin
    rdTagA = entry[rdIdxA];
    rdTagB = entry[rdIdxB];
    rdTagC = entry[rdIdxC];
  end
endmodule

// File: rtl/rr_free_fifo.sv
module rr_free_fifo #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int PHYS_W   = 4,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pop,
  input  logic              push,
  input  logic [PHYS_W-1:0] pushTag,
  output logic [PHYS_W-1:0] headTag,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  localparam int DEPTH = NUM_PHYS;
  localparam int INIT  = NUM_PHYS - NUM_LOG;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PHYS_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic              full, doPop, doPush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (count == '0);
    full    = (count == CNT_W'(DEPTH));
    doPop   = pop && !empty;
    doPush  = push && !full;
    headTag = slot[rdPtr];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        slot[i] <= (i < INIT) ? PHYS_W'(NUM_LOG + i) : '0;
      else if (doPush && (wrPtr == PTR_W'(i)))
        slot[i] <= pushTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= PTR_W'(INIT % DEPTH);
      count <= CNT_W'(INIT);
    end else begin
      if (doPop)  rdPtr <= bump(rdPtr);
      if (doPush) wrPtr <= bump(wrPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  localparam int LOG_W   = $clog2(NUM_LOG),
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [LOG_W-1:0]  srcA,
  input  logic [LOG_W-1:0]  srcB,
  input  logic [LOG_W-1:0]  dst,
  input  logic              relValid,
  input  logic [PHYS_W-1:0] relTag,
  output logic [PHYS_W-1:0] physSrcA,
  output logic [PHYS_W-1:0] physSrcB,
  output logic [PHYS_W-1:0] physDst,
  output logic [PHYS_W-1:0] prevDst,
  output logic              stall
);
  localparam int CNT_W = $clog2(NUM_PHYS + 1);

  rr_pkg::rrStrobes_t strobes;
  logic              freeEmpty;
  logic [PHYS_W-1:0] headTag;
  logic [CNT_W-1:0]  freeCount;

  rr_ctrl #(.LOG_W(LOG_W)) u_ctrl (
    .decValid (decValid),
    .dst      (dst),
    .freeEmpty(freeEmpty),
    .relValid (relValid),
    .strobes  (strobes),
    .stall    (stall)
  );

  rr_map_table #(.NUM_LOG(NUM_LOG), .LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_map (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (strobes.alloc),
    .wrIdx (dst),
    .wrTag (headTag),
    .rdIdxA(srcA),
    .rdIdxB(srcB),
    .rdIdxC(dst),
    .rdTagA(physSrcA),
    .rdTagB(physSrcB),
    .rdTagC(prevDst)
  );

  rr_free_fifo #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_free (
    .clk    (clk),
    .rstN   (rstN),
    .pop    (strobes.alloc),
    .push   (strobes.release_),
    .pushTag(relTag),
    .headTag(headTag),
    .empty  (freeEmpty),
    .count  (freeCount)
  );

  assign physDst = strobes.alloc ? headTag : '0;
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int LOG_W  = 3,
  parameter int PHYS_W = 4,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              decValid,
  input logic [LOG_W-1:0]  srcA,
  input logic [LOG_W-1:0]  srcB,
  input logic [LOG_W-1:0]  dst,
  input logic              relValid,
  input logic [PHYS_W-1:0] physSrcA,
  input logic [PHYS_W-1:0] physSrcB,
  input logic [PHYS_W-1:0] physDst,
  input logic [PHYS_W-1:0] prevDst,
  input logic              stall,
  input logic [CNT_W-1:0]  freeCount
);
  logic grant;
  assign grant = decValid && (dst != '0) && !stall;

  a_r5_zero_src_a: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == '0) |-> (physSrcA == '0));
  a_r5_zero_src_b: assert property (@(posedge clk) disable iff (!rstN)
    (srcB == '0) |-> (physSrcB == '0));
  a_r5_zero_dst: assert property (@(posedge clk) disable iff (!rstN)
    (dst == '0) |-> (physDst == '0 && prevDst == '0 && !stall));
  a_r8_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stall);
  a_r3_fresh_tag: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> (physDst != '0));
  a_r3_count_drop: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !relValid) |=> (freeCount == $past(freeCount) - 1'b1));
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !relValid) |=> $stable(freeCount));
  a_r6_stall_tag: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (physDst == '0 && freeCount == '0));
  a_r7_both_honoured: assert property (@(posedge clk) disable iff (!rstN)
    (grant && relValid) |=> $stable(freeCount));
endmodule

bind reg_rename reg_rename_chk #(.LOG_W(LOG_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .decValid (decValid),
  .srcA     (srcA),
  .srcB     (srcB),
  .dst      (dst),
  .relValid (relValid),
  .physSrcA (physSrcA),
  .physSrcB (physSrcB),
  .physDst  (physDst),
  .prevDst  (prevDst),
  .stall    (stall),
  .freeCount(freeCount)
);

// File: tb/reg_rename_tb.sv
module reg_rename_tb;
  localparam int NL = 8;
  localparam int NP = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0;
  logic [2:0] srcA = '0, srcB = '0, dst = '0;
  logic       relValid = 1'b0;
  logic [3:0] relTag = '0;
  logic [3:0] physSrcA, physSrcB, physDst, prevDst;
  logic       stall;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reg_rename #(.NUM_LOG(NL), .NUM_PHYS(NP)) u_dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .srcA(srcA), .srcB(srcB),
    .dst(dst), .relValid(relValid), .relTag(relTag), .physSrcA(physSrcA),
    .physSrcB(physSrcB), .physDst(physDst), .prevDst(prevDst), .stall(stall)
  );

  // fields: dv sa sb d rv rt | expA expB expD expP expS
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 3'd3, 3'd3, 3'd3, 1'b0, 4'd0, 4'd3,  4'd3,  4'd8,  4'd3, 1'b0}, // R2 own dst read old
    {1'b1, 3'd3, 3'd1, 3'd1, 1'b0, 4'd0, 4'd8,  4'd1,  4'd9,  4'd1, 1'b0}, // R3 second tag
    {1'b1, 3'd0, 3'd1, 3'd3, 1'b0, 4'd0, 4'd0,  4'd9,  4'd10, 4'd8, 1'b0}, // R4 prev of r3
    {1'b1, 3'd3, 3'd2, 3'd0, 1'b0, 4'd0, 4'd10, 4'd2,  4'd0,  4'd0, 1'b0}, // R5 dst zero
    {1'b1, 3'd1, 3'd3, 3'd2, 1'b1, 4'd3, 4'd9,  4'd10, 4'd11, 4'd2, 1'b0}, // R7 rel+alloc
    {1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 4'd8, 4'd0,  4'd0,  4'd0,  4'd0, 1'b0}  // R8 idle release
  };

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(input logic dv, input logic [2:0] sa, input logic [2:0] sb,
                      input logic [2:0] d, input logic rv, input logic [3:0] rt,
                      input logic [3:0] eA, input logic [3:0] eB, input logic [3:0] eD,
                      input logic [3:0] eP, input logic eS, input string req);
    @(negedge clk);
    decValid = dv; srcA = sa; srcB = sb; dst = d; relValid = rv; relTag = rt;
    #5;
    checks++;
    if (physSrcA !== eA || physSrcB !== eB || physDst !== eD || prevDst !== eP || stall !== eS) begin
      errors++;
      $display("FAIL %s: got A=%0d B=%0d D=%0d P=%0d S=%0d expected A=%0d B=%0d D=%0d P=%0d S=%0d",
               req, physSrcA, physSrcB, physDst, prevDst, stall, eA, eB, eD, eP, eS);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; decValid = 1'b0; relValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R1: reset bindings
    step(0, 3'd5, 3'd6, 3'd7, 0, 0, 4'd5, 4'd6, 4'd0, 4'd7, 0, "R1");
    step(0, 3'd1, 3'd3, 3'd0, 0, 0, 4'd1, 4'd3, 4'd0, 4'd0, 0, "R1");
    foreach (VEC[i]) begin
      logic [31:0] v;
      v = VEC[i];
      step(v[31], v[30:28], v[27:25], v[24:22], v[21], v[20:17],
           v[16:13], v[12:9], v[8:5], v[4:1], v[0], "R2/R3/R4/R5/R7/R8 table");
    end
    // R3 drain: free list now 12,13,14,15,3,8
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd12, 4'd4,  0, "R3");
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd13, 4'd12, 0, "R3");
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd14, 4'd13, 0, "R3");
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd15, 4'd14, 0, "R3");
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd3,  4'd15, 0, "R7 released tag 3");
    step(1, 3'd0, 3'd0, 3'd4, 0, 0, 4'd0, 4'd0, 4'd8,  4'd3,  0, "R7 released tag 8");
    // R6: empty list
    step(1, 3'd4, 3'd0, 3'd4, 0, 0, 4'd8, 4'd0, 4'd0, 4'd8, 1, "R6 stall");
    step(1, 3'd4, 3'd1, 3'd0, 0, 0, 4'd8, 4'd9, 4'd0, 4'd0, 0, "R6 map held");
    step(1, 3'd0, 3'd0, 3'd5, 1, 4'd5, 4'd0, 4'd0, 4'd0, 4'd5, 1, "R6 release no bypass");
    step(1, 3'd5, 3'd0, 3'd6, 0, 0, 4'd5, 4'd0, 4'd5, 4'd6, 0, "R7 after stall");
    step(0, 3'd6, 3'd5, 3'd0, 0, 0, 4'd5, 4'd5, 4'd0, 4'd0, 0, "R3 r6 bound");
    // R1 again after reset, R7 simultaneous at full list
    doReset();
    step(1, 3'd1, 3'd2, 3'd1, 1, 4'd1, 4'd1, 4'd2, 4'd8, 4'd1, 0, "R1/R7");
    for (int k = 0; k < 7; k++)
      step(1, 3'd0, 3'd0, 3'd2, 0, 0, 4'd0, 4'd0, 4'(9 + k), (k == 0) ? 4'd2 : 4'(8 + k), 0, "R3 order");
    step(1, 3'd0, 3'd0, 3'd2, 0, 0, 4'd0, 4'd0, 4'd1, 4'd15, 0, "R7 tail order");
    step(1, 3'd2, 3'd1, 3'd2, 0, 0, 4'd1, 4'd8, 4'd0, 4'd1, 1, "R6 empty");
    done = 1;
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      finishRun();
    end
  end
endmodule